// File: doc/BRIEF.md
# Multi-Lane Masked Vector Execution Sequencer

This block runs one integer vector instruction at a time over a set of parallel lanes. The vector register file is split across the lanes element by element: element `e` lives in lane `e % LANES`, in row `e / LANES` of that lane's slice. Every lane has its own pipelined adder, subtractor and multiplier. A shared flag register holds one mask bit per element. An accepted instruction names a destination, two sources, a vector length, a masked flag and a scalar flag. The block then issues one group of `LANES` elements per clock. Each group's write enables, row and destination travel with its results through `DEPTH` pipeline registers before they are written back.

In scalar mode, only element 0 of each source is read. The one result is copied into every lane of the first group (elements `0..LANES-1`) of the destination. A side port loads single elements and the whole mask, and a combinational read port returns any element, so a test or a surrounding datapath can fill the file and observe it.

Top module: `vec_lane_seq`

## Requirements
- R1: Element `e` of register `r`, once loaded through `ld_*`, reads back on `rd_data` when `rd_reg=r`, `rd_elem=e`. Register contents are not cleared by reset.
- R2: Opcode `op` selects the element-wise operation: 2'b00 gives a+b, 2'b01 gives a-b, 2'b10 gives the low `DATA_W` bits of a*b, and 2'b11 copies a. All results wrap modulo 2^`DATA_W`.
- R3: `start` is accepted on a clock edge where `busy` is low. Let N = ceil(VL/LANES)+`DEPTH` (or 1+`DEPTH` in scalar mode). `busy` is high from the accept edge until the Nth edge after it. `done` is high for exactly the one cycle after that edge. At that point all results are in the file.
- R4: `start` while `busy` is high is ignored: no register is written for it and the running instruction keeps its timing.
- R5: With `masked`=1, an element whose mask bit (bit `e` of the loaded mask) is 0 keeps its old destination value. With `masked`=0 the mask has no effect.
- R6: Elements at index VL and above are not written, including the unused lanes of a final partial group.
- R7: A non-scalar instruction with VL=0 writes nothing. It raises `done` in the cycle after the first edge following acceptance.
- R8: With `scalar`=1, VL is ignored. op(a[0],b[0]) is written to elements 0 to `LANES-1` of the destination. If `masked`=1, the write depends on mask bit 0 alone.
- R9: No writeback takes place while `busy` is low.
- R10: After reset, `busy` and `done` are low and the mask is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid |
| op | input | 2 | Operation code |
| dst | input | $clog2(NREGS) | Destination register |
| src_a | input | $clog2(NREGS) | First source register |
| src_b | input | $clog2(NREGS) | Second source register |
| vl | input | $clog2(MAXVL+1) | Vector length |
| masked | input | 1 | Gate writes by mask |
| scalar | input | 1 | Scalar mode |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| ld_we | input | 1 | Element load enable |
| ld_reg | input | $clog2(NREGS) | Load register |
| ld_elem | input | $clog2(MAXVL) | Load element index |
| ld_data | input | DATA_W | Load value |
| mask_we | input | 1 | Mask load enable |
| mask_data | input | MAXVL | Mask bits, bit e for element e |
| rd_reg | input | $clog2(NREGS) | Read register |
| rd_elem | input | $clog2(MAXVL) | Read element index |
| rd_data | output | DATA_W | Element value (combinational) |

## Verification
`busy` rises on the accept edge. `busy` falls, and `done` rises, on the Nth edge after it, where N is the group count plus the pipeline depth. For a VL=0 instruction, N is one. The bench's reference model derives N from the instruction alone. It compares `busy` and `done` at the falling edge after every rising edge of the instruction, plus one more cycle to see the pulse end. Register contents come from the model's integer array, updated with snapshot sources. They are compared through the combinational read port only after `done`, one nanosecond after a falling edge, so no edge lies between drive and sample.

// File: rtl/vec_lane_seq.sv
module vec_lane_seq #(
  parameter int LANES  = 4,
  parameter int DATA_W = 16,
  parameter int NREGS  = 32,
  parameter int MAXVL  = 16,
  parameter int DEPTH  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 op,
  input  logic [$clog2(NREGS)-1:0]   dst,
  input  logic [$clog2(NREGS)-1:0]   src_a,
  input  logic [$clog2(NREGS)-1:0]   src_b,
  input  logic [$clog2(MAXVL+1)-1:0] vl,
  input  logic                       masked,
  input  logic                       scalar,
  output logic                       busy,
  output logic                       done,
  input  logic                       ld_we,
  input  logic [$clog2(NREGS)-1:0]   ld_reg,
  input  logic [$clog2(MAXVL)-1:0]   ld_elem,
  input  logic [DATA_W-1:0]          ld_data,
  input  logic                       mask_we,
  input  logic [MAXVL-1:0]           mask_data,
  input  logic [$clog2(NREGS)-1:0]   rd_reg,
  input  logic [$clog2(MAXVL)-1:0]   rd_elem,
  output logic [DATA_W-1:0]          rd_data
);
  localparam int ROWS = MAXVL / LANES;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int RGW  = $clog2(NREGS);
  localparam int VLW  = $clog2(MAXVL + 1);
  localparam int EW   = $clog2(MAXVL);
  localparam int AW   = $clog2(NREGS * ROWS);
  localparam int CW   = $clog2(ROWS + DEPTH + 2);

  logic [CW-1:0]    cnt, tot, ngrp_r;
  logic [1:0]       i_op;
  logic [RGW-1:0]   i_dst, i_sa, i_sb;
  logic [VLW-1:0]   i_vl;
  logic             i_msk, i_sc;
  logic [MAXVL-1:0] mask_r;

  wire [CW-1:0] ngrp     = CW'((int'(vl) + LANES - 1) / LANES);
  wire [CW-1:0] ngrp_nxt = scalar ? CW'(1) : ngrp;
  wire [CW-1:0] tot_nxt  = (!scalar && vl == '0) ? CW'(1) : ngrp_nxt + CW'(DEPTH);
  wire          issue    = busy && (cnt < ngrp_r);
  wire [RW-1:0] iss_row  = i_sc ? '0 : RW'(cnt);

  logic [DATA_W-1:0]        opa_raw [LANES];
  logic [DATA_W-1:0]        opb_raw [LANES];
  logic [DATA_W-1:0]        rd_lane [LANES];
  logic [LANES-1:0]         iss_we;
  logic [LANES*DATA_W-1:0]  res_flat;

  logic [LANES-1:0]         p_we  [DEPTH];
  logic [RGW-1:0]           p_dst [DEPTH];
  logic [RW-1:0]            p_row [DEPTH];
  logic [LANES*DATA_W-1:0]  p_res [DEPTH];

  logic [LANES-1:0] wb_we;
  wire  [RGW-1:0]   wb_dst = p_dst[DEPTH-1];
  wire  [RW-1:0]    wb_row = p_row[DEPTH-1];
  assign wb_we = p_we[DEPTH-1];

  wire [AW-1:0] sa_addr = AW'(int'(i_sa) * ROWS + int'(iss_row));
  wire [AW-1:0] sb_addr = AW'(int'(i_sb) * ROWS + int'(iss_row));
  wire [AW-1:0] wb_addr = AW'(int'(wb_dst) * ROWS + int'(wb_row));
  wire [AW-1:0] ld_addr = AW'(int'(ld_reg) * ROWS + int'(ld_elem) / LANES);
  wire [AW-1:0] rd_addr = AW'(int'(rd_reg) * ROWS + int'(rd_elem) / LANES);
  wire [LW-1:0] ld_lane = LW'(int'(ld_elem) % LANES);
  wire [LW-1:0] rd_sel  = LW'(int'(rd_elem) % LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DATA_W-1:0] mem [NREGS*ROWS];
    logic [DATA_W-1:0] a_l, b_l;
    wire  [EW-1:0]     eidx   = EW'(int'(cnt) * LANES + l);
    wire               in_len = (int'(cnt) * LANES + l) < int'(i_vl);

    assign opa_raw[l] = mem[sa_addr];
    assign opb_raw[l] = mem[sb_addr];
    assign rd_lane[l] = mem[rd_addr];
    assign a_l = i_sc ? opa_raw[0] : opa_raw[l];
    assign b_l = i_sc ? opb_raw[0] : opb_raw[l];

    assign iss_we[l] = issue && (i_sc ? (!i_msk || mask_r[0])
                                      : (in_len && (!i_msk || mask_r[eidx])));

    assign res_flat[l*DATA_W +: DATA_W] =
        (i_op == 2'd0) ? a_l + b_l :
        (i_op == 2'd1) ? a_l - b_l :
        (i_op == 2'd2) ? a_l * b_l : a_l;

    always_ff @(posedge clk) begin
      if (wb_we[l])
        mem[wb_addr] <= p_res[DEPTH-1][l*DATA_W +: DATA_W];
      else if (ld_we && ld_lane == LW'(l))
        mem[ld_addr] <= ld_data;
    end
  end

  assign rd_data = rd_lane[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) p_we[k] <= '0;
    end else begin
      p_we[0]  <= iss_we;
      p_dst[0] <= i_dst;
      p_row[0] <= iss_row;
      p_res[0] <= res_flat;
      for (int k = 1; k < DEPTH; k++) begin
        p_we[k]  <= p_we[k-1];
        p_dst[k] <= p_dst[k-1];
        p_row[k] <= p_row[k-1];
        p_res[k] <= p_res[k-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      tot    <= '0;
      ngrp_r <= '0;
      i_op   <= '0;
      i_dst  <= '0;
      i_sa   <= '0;
      i_sb   <= '0;
      i_vl   <= '0;
      i_msk  <= 1'b0;
      i_sc   <= 1'b0;
      mask_r <= '0;
    end else begin
      done <= 1'b0;
      if (mask_we) mask_r <= mask_data;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          tot    <= tot_nxt;
          ngrp_r <= (!scalar && vl == '0) ? '0 : ngrp_nxt;
          i_op   <= op;
          i_dst  <= dst;
          i_sa   <= src_a;
          i_sb   <= src_b;
          i_vl   <= vl;
          i_msk  <= masked;
          i_sc   <= scalar;
        end
      end else begin
        cnt <= cnt + CW'(1);
        if (cnt + CW'(1) == tot) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vec_lane_seq_chk.sv
module vec_lane_seq_chk #(
  parameter int LANES = 4,
  parameter int MAXVL = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic                       scalar,
  input logic [$clog2(MAXVL+1)-1:0] vl,
  input logic [LANES-1:0]           wb_we
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_idle_stays_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !scalar && vl == '0) |=> ##1 done);

  assert_no_idle_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|wb_we) |-> busy);
endmodule

bind vec_lane_seq vec_lane_seq_chk #(.LANES(LANES), .MAXVL(MAXVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .scalar(scalar), .vl(vl), .wb_we(wb_we)
);

// File: tb/tb_vec_lane_seq.sv
`timescale 1ns/1ps
module tb_vec_lane_seq;
  localparam int L = 4, W = 16, NR = 32, MV = 16, D = 3;

  logic clk = 0, rst_n = 0;
  logic start = 0, masked = 0, scalar = 0, ld_we = 0, mask_we = 0;
  logic [1:0] op = 0;
  logic [4:0] dst = 0, src_a = 0, src_b = 0, ld_reg = 0, rd_reg = 0;
  logic [4:0] vl = 0;
  logic [3:0] ld_elem = 0, rd_elem = 0;
  logic [W-1:0] ld_data = 0, rd_data;
  logic [MV-1:0] mask_data = 0;
  logic busy, done;

  int checks = 0, fails = 0;
  int refm [NR][MV];
  logic [MV-1:0] rmask = 0;

  always #4 clk = ~clk;

  vec_lane_seq #(.LANES(L), .DATA_W(W), .NREGS(NR), .MAXVL(MV), .DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst(dst), .src_a(src_a),
    .src_b(src_b), .vl(vl), .masked(masked), .scalar(scalar), .busy(busy),
    .done(done), .ld_we(ld_we), .ld_reg(ld_reg), .ld_elem(ld_elem),
    .ld_data(ld_data), .mask_we(mask_we), .mask_data(mask_data),
    .rd_reg(rd_reg), .rd_elem(rd_elem), .rd_data(rd_data));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int calc(int o, int a, int b);
    case (o)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return (a * b) & 16'hFFFF;
      default: return a;
    endcase
  endfunction

  task automatic check_reg(int r, string req);
    for (int e = 0; e < MV; e++) begin
      @(negedge clk);
      rd_reg = 5'(r); rd_elem = 4'(e);
      #1;
      chk(int'(rd_data) == refm[r][e], req, $sformatf("reg %0d elem %0d", r, e),
          int'(rd_data), refm[r][e]);
    end
  endtask

  task automatic set_mask(logic [MV-1:0] m);
    @(negedge clk);
    mask_we = 1; mask_data = m;
    @(negedge clk);
    mask_we = 0;
    rmask = m;
  endtask

  task automatic run(int o, int d, int a, int b, int n, bit mk, bit sc,
                     bit poke, string req);
    int sa [MV];
    int sb [MV];
    int nn;
    for (int e = 0; e < MV; e++) begin sa[e] = refm[a][e]; sb[e] = refm[b][e]; end
    nn = sc ? 1 + D : (n == 0 ? 1 : (n + L - 1) / L + D);
    @(negedge clk);
    start = 1; op = 2'(o); dst = 5'(d); src_a = 5'(a); src_b = 5'(b);
    vl = 5'(n); masked = mk; scalar = sc;
    @(posedge clk);
    @(negedge clk);
    start = 0;
    chk(busy == 1 && done == 0, "R3", "busy/done after accept", {busy, done}, 2);
    for (int k = 1; k <= nn; k++) begin
      if (poke && k == 1) begin
        start = 1; op = 2'd0; dst = 5'd31; src_a = 5'd0; src_b = 5'd0;
        vl = 5'd16; masked = 0; scalar = 0;
      end
      @(negedge clk);
      start = 0;
      chk(busy == (k < nn), poke ? "R4" : req, $sformatf("busy at edge %0d", k),
          int'(busy), int'(k < nn));
      chk(done == (k == nn), "R3", $sformatf("done at edge %0d", k),
          int'(done), int'(k == nn));
    end
    @(negedge clk);
    chk(done == 0 && busy == 0, "R3", "pulse ended", {busy, done}, 0);
    if (sc) begin
      if (!mk || rmask[0])
        for (int l = 0; l < L; l++) refm[d][l] = calc(o, sa[0], sb[0]);
    end else begin
      for (int e = 0; e < n; e++)
        if (!mk || rmask[e]) refm[d][e] = calc(o, sa[e], sb[e]);
    end
    check_reg(d, req);
    if (poke) check_reg(31, "R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R10", "reset outputs", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R10", "idle after reset", {busy, done}, 0);
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < MV; e++) begin
        @(negedge clk);
        refm[r][e] = (r * 4099 + e * 263 + 17 + r * e * 911) & 16'hFFFF;
        ld_we = 1; ld_reg = 5'(r); ld_elem = 4'(e); ld_data = 16'(refm[r][e]);
      end
    @(negedge clk);
    ld_we = 0;
    check_reg(0, "R1");
    check_reg(13, "R1");
    // R10: mask clears on reset, so a masked op writes nothing
    run(0, 29, 3, 4, 16, 1, 0, 0, "R10");
    run(0, 20, 1, 2, 16, 0, 0, 0, "R2");
    run(1, 21, 3, 4, 7, 0, 0, 0, "R6");
    set_mask(16'hA5C3);
    run(2, 22, 5, 6, 16, 1, 0, 0, "R5");
    run(3, 23, 7, 7, 5, 1, 0, 0, "R5");
    run(2, 30, 14, 15, 12, 0, 0, 0, "R2");
    run(0, 24, 8, 9, 0, 0, 0, 0, "R7");
    run(0, 25, 8, 9, 9, 1, 1, 0, "R8");
    set_mask(16'hFFFE);
    run(2, 26, 10, 11, 16, 1, 1, 0, "R8");
    run(1, 1, 1, 2, 0, 0, 1, 0, "R8");
    run(0, 27, 10, 11, 13, 0, 0, 1, "R4");
    run(1, 28, 12, 13, 1, 0, 0, 0, "R6");
    run(0, 2, 2, 2, 16, 0, 0, 0, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule